// File: doc/BRIEF.md
# Queue Condition Interrupt Controller

This block watches the status flags of a bank of hardware FIFO queues and turns chosen conditions into two level interrupt lines. The queues are split into a lower half and an upper half of equal size. Each lower-half queue supplies a four-flag status nibble and has its own three-bit source select. That select picks one flag of the nibble and can invert it. Each upper-half queue supplies a single "at or below low watermark" flag. Its request condition is always the negation of that flag, meaning the queue is not nearly empty.

For each half, a rising edge of a queue's condition sets that queue's bit in a latched status register, but only while the queue is enabled. Software clears status bits by writing ones to the status register. Each interrupt line is high while any enabled queue of its half has a latched bit. Registers are reached through a simple single-cycle write strobe and a combinational read port. The FIFOs themselves are outside the block.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset, every source select, both enable registers and both status registers read zero, and both interrupt outputs are low.
- R2: The register map is as follows. Addresses 0 to 3 are the source select words. Queue q owns bits 4*(q mod 8)+2..4*(q mod 8) of word q/8, and bit 4*(q mod 8)+3 is reserved and reads 0. Address 4 is lower enable, 5 is upper enable, 6 is lower status and 7 is upper status. Within each of these, queue q sits at bit q mod 32.
- R3: For a lower-half queue, select bits 1:0 choose one flag of its nibble `lo_flags[4q+3:4q]`: 0 = empty (bit 0), 1 = nearly empty (bit 1), 2 = nearly full (bit 2), 3 = full (bit 3).
- R4: Select bit 2 inverts the chosen flag before edge detection.
- R5: An upper-half queue's condition is the negation of `hi_low_lvl[q]`. Its status bit is set when that flag falls, and it is not set when the flag rises.
- R6: A status bit is set only by a rising edge of its condition. A condition that stays high does not set the bit again after the bit is cleared.
- R7: A queue whose enable bit is 0 on the edge cycle does not latch. Enabling the queue later while its condition is already high does not set the bit.
- R8: Writing the status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R9: If a set and a clear reach the same status bit in the same cycle, the bit ends up set. Other bits cleared in that write still clear.
- R10: `irq_lo` and `irq_hi` are high while their half has any bit both set and enabled. Disabling a queue drops its contribution but keeps its status bit, and re-enabling the queue brings the interrupt back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| lo_flags | input | 128 | Four status flags per lower-half queue |
| hi_low_lvl | input | 32 | Low-watermark flag per upper-half queue |
| irq_lo | output | 1 | Lower-half interrupt level |
| irq_hi | output | 1 | Upper-half interrupt level |

## Verification
The bench builds the block with the default of 32 queues per half. With that size the map has four select words, so a queue in the second word (queue 9) can be checked next to a queue in the first word (queue 5). A table sweeps all eight select codes on one queue, and each code is checked against an opposite baseline so that both the plain and the inverted senses are seen. Directed tests then check the upper-half fixed source, gating by enable, the partial W1C write, the same-cycle set/clear race, and masking of the interrupt lines.

// File: rtl/qirq_pkg.sv
// Package: shared register-kind type and address decode for the queue
// interrupt controller. Assumes select words come first in the map,
// followed by lower/upper enable and lower/upper status.
package qirq_pkg;

    typedef enum logic [2:0] {
        RK_SEL,
        RK_EN_LO,
        RK_EN_HI,
        RK_ST_LO,
        RK_ST_HI,
        RK_NONE
    } reg_kind_e;

    // Map an address onto the register it selects.
    function automatic reg_kind_e kind_of(input int unsigned addr, input int unsigned nsel);
        if (addr < nsel)          return RK_SEL;
        else if (addr == nsel)     return RK_EN_LO;
        else if (addr == nsel + 1) return RK_EN_HI;
        else if (addr == nsel + 2) return RK_ST_LO;
        else if (addr == nsel + 3) return RK_ST_HI;
        else                       return RK_NONE;
    endfunction

endpackage

// File: rtl/qirq_srcsel.sv
// Module: per-queue source select storage and condition derivation for the
// lower half. Each queue holds 3 select bits in a 4-bit slot of a word;
// bits 1:0 pick a status flag, bit 2 inverts it. Assumes DW is a multiple
// of 4 and HALF_Q a multiple of DW/4.
module qirq_srcsel #(
    parameter  int HALF_Q  = 32,
    parameter  int DW      = 32,
    localparam int QPW     = DW / 4,
    localparam int SWORDS  = HALF_Q / QPW,
    localparam int SIDX_W  = (SWORDS > 1) ? $clog2(SWORDS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SIDX_W-1:0]      wr_idx,
    input  logic [DW-1:0]          wdata,
    input  logic [4*HALF_Q-1:0]    lo_flags,
    output logic [SWORDS*DW-1:0]   sel_flat,
    output logic [HALF_Q-1:0]      cond
);

    logic [2:0] sel_q [HALF_Q];

    for (genvar g = 0; g < HALF_Q; g++) begin : g_q
        localparam int W = g / QPW;
        localparam int P = g % QPW;
        logic [3:0] nib;

        // Capture this queue's field when its word is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[g] <= 3'd0;
            else if (wr_en && wr_idx == SIDX_W'(W))
                sel_q[g] <= wdata[4*P +: 3];
        end

        assign nib            = lo_flags[4*g +: 4];
        assign cond[g]        = nib[sel_q[g][1:0]] ^ sel_q[g][2];
        assign sel_flat[4*g +: 4] = {1'b0, sel_q[g]};
    end

endmodule

// File: rtl/qirq_latch.sv
// Module: one half's enable register, rising-edge request latch with
// write-one-to-clear, and level interrupt. Assumes cond is synchronous to clk.
module qirq_latch #(
    parameter int HALF_Q = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_Q-1:0] cond,
    input  logic              en_we,
    input  logic              st_we,
    input  logic [HALF_Q-1:0] wdata,
    output logic [HALF_Q-1:0] en_o,
    output logic [HALF_Q-1:0] st_o,
    output logic              irq_o
);

    logic [HALF_Q-1:0] cond_q, en_q, st_q, set, clr;

    // Combine edge detection, enable gating and software clear.
    always_comb begin
        set = cond & ~cond_q & en_q;
        clr = st_we ? wdata : '0;
    end

    // Remember the previous condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond;
    end

    // Hold the enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // Latch requests; a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr) | set;
    end

    assign en_o  = en_q;
    assign st_o  = st_q;
    assign irq_o = |(st_q & en_q);

    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q & ~$past(st_q) & $past(cond_q))) == 1'b0); // R6
    AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q & ~$past(st_q) & ~$past(en_q))) == 1'b0); // R7
    AST_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~st_q & $past(st_q) & ~$past(clr))) == 1'b0); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(set & clr) & ~st_q)) == 1'b0); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q != '0)); // R10

endmodule

// File: rtl/qirq_ctrl.sv
// Module: top of the queue condition interrupt controller. Decodes the
// register map, routes lower-half conditions through the source selects,
// gives upper-half queues the fixed not-nearly-empty source, and drives one
// interrupt per half. Assumes registers are HALF_Q bits wide.
module qirq_ctrl
    import qirq_pkg::*;
#(
    parameter  int HALF_Q = 32,
    localparam int DW     = HALF_Q,
    localparam int QPW    = DW / 4,
    localparam int SWORDS = HALF_Q / QPW,
    localparam int SIDX_W = (SWORDS > 1) ? $clog2(SWORDS) : 1,
    localparam int ADDR_W = $clog2(SWORDS + 4)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [4*HALF_Q-1:0] lo_flags,
    input  logic [HALF_Q-1:0]   hi_low_lvl,
    output logic                irq_lo,
    output logic                irq_hi
);

    reg_kind_e           kind;
    logic [SWORDS*DW-1:0] sel_flat;
    logic [HALF_Q-1:0]   cond_lo;
    logic [HALF_Q-1:0]   cond_h [2];
    logic [HALF_Q-1:0]   en_h   [2];
    logic [HALF_Q-1:0]   st_h   [2];
    logic [1:0]          irq_v;
    logic [SIDX_W-1:0]   sel_idx;

    assign kind    = kind_of(32'(reg_addr), SWORDS);
    assign sel_idx = reg_addr[SIDX_W-1:0];

    qirq_srcsel #(.HALF_Q(HALF_Q), .DW(DW)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we && kind == RK_SEL),
        .wr_idx   (sel_idx),
        .wdata    (reg_wdata),
        .lo_flags (lo_flags),
        .sel_flat (sel_flat),
        .cond     (cond_lo)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        if (h == 0) begin : g_lo
            assign cond_h[h] = cond_lo;
        end else begin : g_hi
            assign cond_h[h] = ~hi_low_lvl;
        end

        qirq_latch #(.HALF_Q(HALF_Q)) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (cond_h[h]),
            .en_we (reg_we && kind == ((h == 0) ? RK_EN_LO : RK_EN_HI)),
            .st_we (reg_we && kind == ((h == 0) ? RK_ST_LO : RK_ST_HI)),
            .wdata (reg_wdata),
            .en_o  (en_h[h]),
            .st_o  (st_h[h]),
            .irq_o (irq_v[h])
        );
    end

    // Select the addressed register onto the read port.
    always_comb begin
        case (kind)
            RK_SEL:   reg_rdata = sel_flat[int'(sel_idx)*DW +: DW];
            RK_EN_LO: reg_rdata = en_h[0];
            RK_EN_HI: reg_rdata = en_h[1];
            RK_ST_LO: reg_rdata = st_h[0];
            RK_ST_HI: reg_rdata = st_h[1];
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_lo = irq_v[0];
    assign irq_hi = irq_v[1];

endmodule

// File: tb/sim_qirq_ctrl.sv
module sim_qirq_ctrl;

    localparam int CLK_PERIOD = 10;

    // Table entry: {expected latch, select code[2:0], nibble applied[3:0]}
    localparam logic [7:0] TBL [8] = '{
        8'b1_000_0001, 8'b0_001_0000, 8'b1_010_0100, 8'b1_011_1000,
        8'b0_100_0001, 8'b1_101_0000, 8'b1_110_1011, 8'b0_111_1000
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] lo_flags = '0;
    logic [31:0]  hi_low_lvl = '1;
    logic         irq_lo, irq_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_flags(lo_flags),
        .hi_low_lvl(hi_low_lvl), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = a[2:0];
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1: reset state of every register and both lines
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk("R1 reg", d, 32'h0);
        end
        chk("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
        chk("R1 irq_hi", {31'b0, irq_hi}, 32'h0);

        // R2: reserved bits read zero
        wr(1, 32'hFFFF_FFFF);
        rd(1, d);
        chk("R2 reserved", d, 32'h7777_7777);
        wr(1, 32'h0);

        // R3/R4: sweep select codes on queue 5 (word 0 bits 22:20)
        wr(4, 32'h1 << 5);
        for (int i = 0; i < 8; i++) begin
            wr(0, 32'(TBL[i][6:4]) << 20);
            lo_flags[23:20] = ~TBL[i][3:0];
            step(); step();
            wr(6, 32'hFFFF_FFFF);
            lo_flags[23:20] = TBL[i][3:0];
            step(); step();
            rd(6, d);
            chk(i < 4 ? "R3 select" : "R4 invert", {31'b0, d[5]}, {31'b0, TBL[i][7]});
        end
        wr(0, 32'h0);
        lo_flags[23:20] = 4'h0;
        step();
        wr(6, 32'hFFFF_FFFF);

        // R2/R3: queue 9 in word 1 selects full; queue 8 stays quiet
        wr(4, (32'h1 << 9) | (32'h1 << 8));
        wr(1, 32'h3 << 4);
        lo_flags[39:36] = 4'b1000;
        step(); step();
        rd(6, d);
        chk("R2 word1 queue9", d, 32'h1 << 9);
        chk("R10 irq_lo set", {31'b0, irq_lo}, 32'h1);

        // R6: condition held high; after clear nothing re-latches
        wr(6, 32'h1 << 9);
        step(); step();
        rd(6, d);
        chk("R6 level no relatch", d, 32'h0);
        chk("R10 irq_lo clear", {31'b0, irq_lo}, 32'h0);
        lo_flags[39:36] = 4'b0000;
        step();

        // R7: edge while disabled, then enable with condition high
        wr(0, 32'h0);
        lo_flags[24] = 1'b1;
        step(); step();
        rd(6, d);
        chk("R7 disabled edge", d, 32'h0);
        wr(4, (32'h1 << 6) | (32'h1 << 5) | (32'h1 << 9));
        step(); step();
        rd(6, d);
        chk("R7 late enable", d, 32'h0);
        chk("R7 irq_lo", {31'b0, irq_lo}, 32'h0);
        lo_flags[24] = 1'b0;
        step();

        // R8: partial write-one-to-clear
        lo_flags[20] = 1'b1;
        lo_flags[39] = 1'b1;
        step(); step();
        rd(6, d);
        chk("R8 both set", d, (32'h1 << 5) | (32'h1 << 9));
        wr(6, 32'h1 << 5);
        rd(6, d);
        chk("R8 partial clear", d, 32'h1 << 9);

        // R9: set and clear on queue 5 in the same cycle; queue 9 clears
        lo_flags[20] = 1'b0;
        step(); step();
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = (32'h1 << 5) | (32'h1 << 9);
        lo_flags[20] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(6, d);
        chk("R9 set wins", d, 32'h1 << 5);

        // R10: masking keeps status; re-enable restores the line
        wr(4, 32'h0);
        rd(6, d);
        chk("R10 status kept", d, 32'h1 << 5);
        chk("R10 masked", {31'b0, irq_lo}, 32'h0);
        wr(4, 32'h1 << 5);
        chk("R10 re-enabled", {31'b0, irq_lo}, 32'h1);

        // R5: upper half fixed not-nearly-empty source on queue 35
        wr(5, 32'h1 << 3);
        hi_low_lvl[3] = 1'b0;
        step(); step();
        rd(7, d);
        chk("R5 falling flag sets", d, 32'h1 << 3);
        chk("R5 irq_hi", {31'b0, irq_hi}, 32'h1);
        wr(7, 32'hFFFF_FFFF);
        hi_low_lvl[3] = 1'b1;
        step(); step();
        rd(7, d);
        chk("R5 rising flag quiet", d, 32'h0);
        chk("R5 irq_hi low", {31'b0, irq_hi}, 32'h0);
        rd(6, d);
        chk("R5 lower untouched", d, 32'h1 << 5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule